// File: doc/BRIEF.md
# Eight-Bit Float Expander

This block widens one 8-bit floating-point code into an IEEE binary32 or binary16 word. Two 8-bit layouts are accepted: one with four exponent bits and three fraction bits, and one with five exponent bits and two fraction bits. Both use an encoding that has a single zero (all bits clear) and a single NaN (only the sign bit set). There are no infinities and no negative zero. In exchange, each exponent bias is one larger than the usual IEEE choice.

A caller presents a code, a layout select and a width select with a valid/ready handshake. The expanded word comes back one register stage later on a 32-bit output. In half-width mode the binary16 result sits in bits 15:0. Every finite code is representable in both output widths, so the expansion is exact and no rounding is involved. Codes whose exponent field is zero are normalised with a leading-zero count. Small five-exponent-bit values that fall below the binary16 normal range leave as binary16 subnormals.

Top module: `fp8x_expand`

## Requirements
- R1: Bit 7 is the sign. When `in_fmt`=0 the exponent is bits 6:3, the fraction is bits 2:0 and the bias is 8. When `in_fmt`=1 the exponent is bits 6:2, the fraction is bits 1:0 and the bias is 16. A code with nonzero exponent field e and fraction f of width w has value 2^(e-bias)·(1+f/2^w).
- R2: Code 0x00 expands to an all-zero output word in both widths.
- R3: Code 0x80 expands to 0x7FC00000 when `in_half`=0 and to 0x00007E00 when `in_half`=1.
- R4: For every code other than 0x00 and 0x80, the output sign bit equals input bit 7. The output sign bit is bit 31 for binary32 and bit 15 for binary16.
- R5: A code with zero exponent field and nonzero fraction has value 2^(1-bias)·f/2^w and is expanded exactly.
- R6: With `in_half`=0, every finite code gives the exact binary32 encoding of its value.
- R7: With `in_half`=1, bits 15:0 hold the exact binary16 encoding of the value and bits 31:16 are zero.
- R8: With `in_fmt`=1 and `in_half`=1, values below 2^-14 come out as binary16 subnormals (exponent field 0). Examples: 0x04→0x0200, 0x01→0x0080, 0x83→0x8180. The code 0x08 gives the normal word 0x0400.
- R9: An input is taken when `in_valid` and `in_ready` are both high at a clock edge. Its result appears on `out_word` with `out_valid` high after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold and `in_ready` is low.
- R11: A synchronous active-high `rst` clears `out_valid` and raises `in_ready`, even with an unconsumed result pending.
- R12: Every code other than 0x80 maps back to itself when the output value is matched against the nearest code of the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input code present |
| in_ready | output | 1 | Block can take a code this cycle |
| in_code | input | 8 | 8-bit floating-point code |
| in_fmt | input | 1 | 0: four exponent bits, 1: five exponent bits |
| in_half | input | 1 | 0: binary32 output, 1: binary16 output |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Expanded word; binary16 in bits 15:0 |

## Verification
The hardest path to reach is the five-exponent-bit to binary16 subnormal path. Only a few codes land there, and each needs a different right shift of the reconstructed significand. The stimulus drives every code of both layouts in both widths, so all shift amounts and all leading-zero counts occur. It also drives a fixed set of boundary codes whose expected words are known in advance. A stalled-consumer sequence followed by a reset reaches the hold and clear behaviour of the output register.

// File: rtl/fp8x_pkg.sv
package fp8x_pkg;

    localparam int CODE_W     = 8;
    localparam int OUT_W      = 32;
    localparam int MAN_MAX    = 3;
    localparam int EXPF_MAX   = 5;
    localparam int EXP_W      = 10;

    localparam int NARROW_EW  = 4;
    localparam int WIDE_EW    = 5;

    localparam int SP_EXP_W   = 8;
    localparam int SP_MAN_W   = 23;
    localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
    localparam int HP_EXP_W   = 5;
    localparam int HP_MAN_W   = 10;
    localparam int HP_BIAS    = (1 << (HP_EXP_W - 1)) - 1;
    localparam int SP_PAD     = SP_MAN_W - MAN_MAX;
    localparam int HP_PAD     = HP_MAN_W - MAN_MAX;
    localparam int HALF_W     = 1 + HP_EXP_W + HP_MAN_W;

    localparam logic [OUT_W-1:0]  SP_QNAN = 32'h7FC0_0000;
    localparam logic [HALF_W-1:0] HP_QNAN = 16'h7E00;
    localparam logic [CODE_W-1:0] NAN_CODE = 8'h80;

    typedef enum logic { FMT_NARROW = 1'b0, FMT_WIDE = 1'b1 } fp8_fmt_e;
    typedef enum logic { OUT_SINGLE = 1'b0, OUT_HALF = 1'b1 } out_width_e;

    typedef struct packed {
        logic                sign;
        logic                zero;
        logic                nan;
        logic [EXPF_MAX-1:0] exp_field;
        logic [MAN_MAX-1:0]  man;
        fp8_fmt_e            fmt;
    } fp8_fields_t;

    typedef struct packed {
        logic                    sign;
        logic                    zero;
        logic                    nan;
        logic signed [EXP_W-1:0] exp_unb;
        logic [MAN_MAX-1:0]      frac;
    } fp8_norm_t;

    // bias is one above the IEEE value for this encoding
    function automatic int fp8_bias(fp8_fmt_e f);
        return (f == FMT_WIDE) ? (1 << (WIDE_EW - 1)) : (1 << (NARROW_EW - 1));
    endfunction

    function automatic int lead_zeros(logic [MAN_MAX-1:0] m);
        int n;
        n = MAN_MAX;
        for (int i = 0; i < MAN_MAX; i++) begin
            if (m[i]) n = MAN_MAX - 1 - i;
        end
        return n;
    endfunction

endpackage

// File: rtl/fp8x_split.sv
module fp8x_split
    import fp8x_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  fp8_fmt_e          fmt,
    output fp8_fields_t       fields
);
    localparam int N_MAN = CODE_W - 1 - NARROW_EW;
    localparam int W_MAN = CODE_W - 1 - WIDE_EW;

    always_comb begin
        fields.sign = code[CODE_W-1];
        fields.zero = (code == '0);
        fields.nan  = (code == NAN_CODE);
        fields.fmt  = fmt;
        if (fmt == FMT_WIDE) begin
            fields.exp_field = code[CODE_W-2:W_MAN];
            fields.man       = {code[W_MAN-1:0], {(MAN_MAX-W_MAN){1'b0}}};
        end else begin
            fields.exp_field = {{(EXPF_MAX-NARROW_EW){1'b0}}, code[CODE_W-2:N_MAN]};
            fields.man       = code[N_MAN-1:0];
        end
    end
endmodule

// File: rtl/fp8x_normalize.sv
module fp8x_normalize
    import fp8x_pkg::*;
(
    input  fp8_fields_t fields,
    output fp8_norm_t   norm
);
    int bias_i;
    int lz_i;

    always_comb begin
        bias_i    = fp8_bias(fields.fmt);
        lz_i      = lead_zeros(fields.man);
        norm.sign = fields.sign;
        norm.zero = fields.zero;
        norm.nan  = fields.nan;
        if (fields.exp_field == '0) begin
            norm.exp_unb = EXP_W'(1 - bias_i - (lz_i + 1));
            norm.frac    = fields.man << (lz_i + 1);
        end else begin
            norm.exp_unb = EXP_W'(int'(fields.exp_field) - bias_i);
            norm.frac    = fields.man;
        end
    end
endmodule

// File: rtl/fp8x_pack.sv
module fp8x_pack
    import fp8x_pkg::*;
(
    input  fp8_norm_t        norm,
    input  out_width_e       width,
    output logic [OUT_W-1:0] word
);
    logic signed [EXP_W-1:0] be;
    logic [HP_MAN_W:0]       sig;
    logic [HP_MAN_W-1:0]     sub;
    logic [3:0]              sh;

    always_comb begin
        be   = '0;
        sh   = '0;
        sig  = {1'b1, norm.frac, HP_PAD'(0)};
        sub  = '0;
        word = '0;
        if (norm.nan) begin
            word = (width == OUT_HALF) ? {{(OUT_W-HALF_W){1'b0}}, HP_QNAN} : SP_QNAN;
        end else if (norm.zero) begin
            word = '0;
        end else if (width == OUT_SINGLE) begin
            be   = norm.exp_unb + EXP_W'(SP_BIAS);
            word = {norm.sign, SP_EXP_W'(be), norm.frac, SP_PAD'(0)};
        end else begin
            be = norm.exp_unb + EXP_W'(HP_BIAS);
            if (be > 0) begin
                word = {{(OUT_W-HALF_W){1'b0}}, norm.sign, HP_EXP_W'(be),
                        norm.frac, HP_PAD'(0)};
            end else begin
                sh   = 4'(1 - be);
                sub  = HP_MAN_W'(sig >> sh);
                word = {{(OUT_W-HALF_W){1'b0}}, norm.sign, {HP_EXP_W{1'b0}}, sub};
            end
        end
    end
endmodule

// File: rtl/fp8x_expand.sv
module fp8x_expand
    import fp8x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_fmt,
    input  logic              in_half,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_word
);
    fp8_fields_t      fields;
    fp8_norm_t        norm;
    logic [OUT_W-1:0] conv_word;
    logic             take;

    fp8x_split u_split (
        .code   (in_code),
        .fmt    (fp8_fmt_e'(in_fmt)),
        .fields (fields)
    );

    fp8x_normalize u_norm (
        .fields (fields),
        .norm   (norm)
    );

    fp8x_pack u_pack (
        .norm  (norm),
        .width (out_width_e'(in_half)),
        .word  (conv_word)
    );

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_word  <= conv_word;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (in_code == '0) |-> (conv_word == '0));

    assert_nan_R3: assert property (@(posedge clk) disable iff (rst)
        norm.nan |-> (conv_word == (in_half ? {16'h0, HP_QNAN} : SP_QNAN)));

    assert_upper_clear_R7: assert property (@(posedge clk) disable iff (rst)
        in_half |-> (conv_word[OUT_W-1:HALF_W] == '0));

    assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (!norm.nan && !norm.zero) |->
        ((in_half ? conv_word[HALF_W-1] : conv_word[OUT_W-1]) == in_code[CODE_W-1]));

    assert_exp_range_R5: assert property (@(posedge clk) disable iff (rst)
        (!norm.nan && !norm.zero) |-> (norm.exp_unb >= -17 && norm.exp_unb <= 15));
endmodule

// File: tb/fp8x_expand_bench.sv
module fp8x_expand_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_code = 8'h00;
    logic        in_fmt = 1'b0;
    logic        in_half = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp8x_expand u_fp8x_expand (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .in_fmt(in_fmt), .in_half(in_half),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic real pow2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real code_real(logic [7:0] c, logic f);
        int  wm   = f ? 2 : 3;
        int  bias = f ? 16 : 8;
        int  e    = f ? int'(c[6:2]) : int'(c[6:3]);
        int  m    = f ? int'(c[1:0]) : int'(c[2:0]);
        real mag;
        if (e == 0) mag = pow2(1 - bias) * real'(m) / pow2(wm);
        else        mag = pow2(e - bias) * (1.0 + real'(m) / pow2(wm));
        return c[7] ? -mag : mag;
    endfunction

    function automatic logic [31:0] real_to_bits(real v, logic h);
        logic [63:0] d;
        logic [10:0] sg;
        logic [10:0] sub;
        int de;
        int e;
        if (v == 0.0) return 32'h0;
        d  = $realtobits(v);
        de = int'(d[62:52]);
        if (!h) return {d[63], 8'(de - 896), d[51:29]};
        e = de - 1008;
        if (e > 0) return {16'h0, d[63], 5'(e), d[51:42]};
        sg  = {1'b1, d[51:42]};
        sub = sg >> (1 - e);
        return {16'h0, d[63], 5'h0, sub[9:0]};
    endfunction

    function automatic logic [31:0] model(logic [7:0] c, logic f, logic h);
        if (c == 8'h80) return h ? 32'h0000_7E00 : 32'h7FC0_0000;
        return real_to_bits(code_real(c, f), h);
    endfunction

    function automatic real word_real(logic [31:0] w, logic h);
        int  e;
        real mag;
        bit  s;
        if (h) begin
            s = w[15]; e = int'(w[14:10]);
            mag = (e == 0) ? real'(w[9:0]) * pow2(-24)
                           : pow2(e - 15) * (1.0 + real'(w[9:0]) * pow2(-10));
        end else begin
            s = w[31]; e = int'(w[30:23]);
            mag = (e == 0) ? real'(w[22:0]) * pow2(-149)
                           : pow2(e - 127) * (1.0 + real'(w[22:0]) * pow2(-23));
        end
        return s ? -mag : mag;
    endfunction

    task automatic convert(input logic [7:0] c, input logic f, input logic h,
                           output logic [31:0] w, output logic v);
        @(negedge clk);
        in_code = c; in_fmt = f; in_half = h; in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        v = out_valid;
        w = out_word;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", {31'h0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R11 reset in_ready", {31'h0, in_ready}, 32'h1);
        rst = 1'b0;
    endtask

    task automatic test_fixed_points();
        logic [31:0] w;
        logic v;
        convert(8'h38, 1'b0, 1'b0, w, v);
        check(v && w == 32'h3F00_0000, "R1 narrow 0x38", w, 32'h3F00_0000);
        convert(8'h3C, 1'b1, 1'b0, w, v);
        check(v && w == 32'h3F00_0000, "R1 wide 0x3C", w, 32'h3F00_0000);
        convert(8'h7F, 1'b0, 1'b0, w, v);
        check(w == 32'h4370_0000, "R1 narrow max", w, 32'h4370_0000);
        for (int f = 0; f < 2; f++) begin
            for (int h = 0; h < 2; h++) begin
                convert(8'h00, 1'(f), 1'(h), w, v);
                check(v && w == 32'h0, "R2 zero", w, 32'h0);
                convert(8'h80, 1'(f), 1'(h), w, v);
                check(w == (h != 0 ? 32'h0000_7E00 : 32'h7FC0_0000), "R3 nan", w,
                      (h != 0 ? 32'h0000_7E00 : 32'h7FC0_0000));
            end
        end
    endtask

    task automatic test_half_subnormals();
        logic [31:0] w;
        logic v;
        convert(8'h04, 1'b1, 1'b1, w, v);
        check(w == 32'h0000_0200, "R8 0x04", w, 32'h0000_0200);
        convert(8'h01, 1'b1, 1'b1, w, v);
        check(w == 32'h0000_0080, "R8 0x01", w, 32'h0000_0080);
        convert(8'h83, 1'b1, 1'b1, w, v);
        check(w == 32'h0000_8180, "R8 0x83", w, 32'h0000_8180);
        convert(8'h08, 1'b1, 1'b1, w, v);
        check(w == 32'h0000_0400, "R8 0x08 normal", w, 32'h0000_0400);
    endtask

    task automatic test_sweep();
        logic [31:0] w;
        logic [31:0] exp;
        logic v;
        string tag;
        for (int f = 0; f < 2; f++) begin
            for (int h = 0; h < 2; h++) begin
                for (int c = 0; c < 256; c++) begin
                    convert(8'(c), 1'(f), 1'(h), w, v);
                    exp = model(8'(c), 1'(f), 1'(h));
                    if ((f != 0 ? (c & 8'h7C) : (c & 8'h78)) == 0 && (c & 8'h7F) != 0)
                        tag = "R5 subnormal";
                    else if (h != 0) tag = "R7 half";
                    else tag = "R6 single";
                    check(v && w == exp, tag, w, exp);
                    if (c > 8'h80) begin
                        check((h != 0 ? w[15] : w[31]) == 1'b1, "R4 sign", w, exp);
                    end
                end
            end
        end
    endtask

    task automatic test_roundtrip();
        logic [31:0] w;
        logic v;
        real r;
        int found;
        for (int f = 0; f < 2; f++) begin
            for (int h = 0; h < 2; h++) begin
                for (int c = 0; c < 256; c++) begin
                    if (c == 8'h80) continue;
                    convert(8'(c), 1'(f), 1'(h), w, v);
                    r = word_real(w, 1'(h));
                    found = -1;
                    for (int k = 0; k < 256; k++) begin
                        if (k != 8'h80 && found < 0 && code_real(8'(k), 1'(f)) == r)
                            found = k;
                    end
                    check(found == c, "R12 roundtrip", 32'(found), 32'(c));
                end
            end
        end
    endtask

    task automatic test_backpressure();
        logic [31:0] a_exp;
        logic [31:0] b_exp;
        a_exp = model(8'h45, 1'b0, 1'b0);
        b_exp = model(8'hC6, 1'b1, 1'b0);
        @(negedge clk);
        out_ready = 1'b0;
        in_code = 8'h45; in_fmt = 1'b0; in_half = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_word == a_exp, "R9 accepted", out_word, a_exp);
        check(in_ready == 1'b0, "R10 stall ready", {31'h0, in_ready}, 32'h0);
        in_code = 8'hC6; in_fmt = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_word == a_exp, "R10 hold", out_word, a_exp);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_word == b_exp, "R9 next taken", out_word, b_exp);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 drained", {31'h0, out_valid}, 32'h0);
        in_code = 8'h11; in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R11 reset pending", {31'h0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R11 ready after reset", {31'h0, in_ready}, 32'h1);
        out_ready = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_fixed_points();
        test_half_subnormals();
        test_sweep();
        test_roundtrip();
        test_backpressure();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule